// File: doc/BRIEF.md
# Video Processor Host Access Port

This block is the host side of a video processor. It exposes two byte-wide ports, chosen by a select bit: a command port and a data port. Through the command port the host sends a two-byte sequence. The sequence sets a 14-bit video memory pointer and picks one of four access kinds: read setup, video memory write, register load or colour memory write. Through the data port the host then streams bytes into video memory or colour memory, or out of video memory. The pointer advances after every data access.

Reads use a one-byte look-ahead buffer. A read-setup command fetches the byte at the new pointer into the buffer at once. Each data read then hands the host the buffered byte and refills the buffer from the pointer. A read of the command port returns the status byte supplied by the timing logic. It also emits a one-cycle clear pulse for the status flags and the pending interrupts. Video memory is external and synchronous, with a one-cycle read latency. While a refill is in flight the port holds `cpu_ready` low and takes no access.

Top module: `vid_host_port`

## Requirements
- R1: After reset `cpu_ready` is 1, `cpu_rvalid`, `vram_we`, `cram_we`, `reg_we`, `stat_clr` and `irq_clr` are 0, and the next command-port write is treated as a first byte.
- R2: A first command byte replaces pointer bits [7:0] with the byte, keeps bits [13:8], stores the byte, marks the sequence half-done and drives no write strobe.
- R3: A second command byte sets the access kind to byte bits [7:6] (0 read setup, 1 video write, 2 register load, 3 colour write) and the pointer to {byte[5:0], stored byte}. For kind 0 it drives `vram_re` with that address in the same cycle, lowers `cpu_ready` for the following cycle, and leaves the pointer at that address plus 1.
- R4: A second command byte of kind 2 pulses `reg_we` in the same cycle, with `reg_idx` = byte[3:0] and `reg_wdata` = the stored first byte.
- R5: A data-port write under kind 0, 1 or 2 drives `vram_we` in the same cycle at the pointer and then increments the pointer modulo 2^14 (0x3FFF wraps to 0x0000).
- R6: A data-port write under kind 3 drives `cram_we` at pointer bits [4:0] and not `vram_we`, then increments the pointer.
- R7: A data-port read presents the buffered byte on `cpu_rdata` with `cpu_rvalid` high in the next cycle, refills the buffer from video memory at the pointer and increments the pointer.
- R8: Any data-port read or write abandons a half-done command sequence, so the next command byte is again a first byte.
- R9: A command-port read presents `status_in` on `cpu_rdata` with `cpu_rvalid` in the next cycle, pulses `stat_clr` and `irq_clr` for exactly that one cycle, and abandons a half-done command sequence.
- R10: While `cpu_ready` is 0, strobes are ignored: no write strobe is driven and neither the pointer nor the sequence state changes. When both strobes are high, the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Host write strobe |
| cpu_rd | input | 1 | Host read strobe |
| cpu_sel | input | 1 | 0 data port, 1 command/status port |
| cpu_wdata | input | 8 | Host write byte |
| cpu_rdata | output | 8 | Read byte, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read result valid |
| cpu_ready | output | 1 | Port accepts an access this cycle |
| vram_we | output | 1 | Video memory write enable |
| vram_waddr | output | 14 | Video memory write address |
| vram_wdata | output | 8 | Video memory write byte |
| vram_re | output | 1 | Video memory read enable |
| vram_raddr | output | 14 | Video memory read address |
| vram_rdata | input | 8 | Video memory read byte, one cycle after vram_re |
| cram_we | output | 1 | Colour memory write enable |
| cram_addr | output | 5 | Colour memory entry |
| cram_wdata | output | 8 | Colour memory write byte |
| reg_we | output | 1 | Register load strobe |
| reg_idx | output | 4 | Register index |
| reg_wdata | output | 8 | Register value |
| status_in | input | 8 | Status byte from the timing logic |
| stat_clr | output | 1 | One-cycle status clear pulse |
| irq_clr | output | 1 | One-cycle interrupt-pending clear pulse |

## Verification
Write strobes toward the memories and the register file are combinational and due in the cycle the access is accepted. The bench samples them 1 time unit after it drives the strobe, before that cycle's rising edge. Read results and the clear pulses are registered, so they are due one cycle later. The bench samples them at the next falling edge, and samples once more a cycle after that to show that the clear pulse has dropped. After a read setup or a data read, the buffer refill holds `cpu_ready` low for one cycle. The bench checks that gap and waits for `cpu_ready` before each access. It also drives one write into the gap to show that the write is ignored.

// File: rtl/vhp_pkg.sv
package vhp_pkg;
  typedef enum logic [1:0] {
    ACC_VRD = 2'd0,
    ACC_VWR = 2'd1,
    ACC_REG = 2'd2,
    ACC_CWR = 2'd3
  } acc_code_e;
endpackage

// File: rtl/vhp_rst_sync.sv
module vhp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/vhp_cmd.sv
module vhp_cmd
  import vhp_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter int REG_IW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              dat_acc,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr,
  output acc_code_e         code,
  output logic              setup_fetch,
  output logic [ADDR_W-1:0] setup_addr,
  output logic              reg_we,
  output logic [REG_IW-1:0] reg_idx,
  output logic [DATA_W-1:0] reg_wdata
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              pend_q, pend_d;
  logic [DATA_W-1:0] latch_q, latch_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  acc_code_e         code_q, code_d;
  logic              first_b, second_b, upd_en;
  acc_code_e         new_code;

  assign first_b     = ctl_wr & ~pend_q;
  assign second_b    = ctl_wr & pend_q;
  assign upd_en      = ctl_wr | dat_acc | stat_rd;
  assign new_code    = acc_code_e'(wdata[DATA_W-1 -: 2]);
  assign setup_addr  = {wdata[HI_W-1:0], latch_q};
  assign setup_fetch = second_b && (new_code == ACC_VRD);
  assign reg_we      = second_b && (new_code == ACC_REG);
  assign reg_idx     = wdata[REG_IW-1:0];
  assign reg_wdata   = latch_q;

  always_comb begin
    pend_d  = pend_q;
    latch_d = latch_q;
    addr_d  = addr_q;
    code_d  = code_q;
    if (first_b) begin
      addr_d  = {addr_q[ADDR_W-1:DATA_W], wdata};
      latch_d = wdata;
      pend_d  = 1'b1;
    end else if (second_b) begin
      pend_d = 1'b0;
      code_d = new_code;
      addr_d = setup_fetch ? (setup_addr + ADDR_ONE) : setup_addr;
    end else if (dat_acc) begin
      pend_d = 1'b0;
      addr_d = addr_q + ADDR_ONE;
    end else if (stat_rd) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      latch_q <= '0;
      addr_q  <= '0;
      code_q  <= ACC_VRD;
    end else if (upd_en) begin
      pend_q  <= pend_d;
      latch_q <= latch_d;
      addr_q  <= addr_d;
      code_q  <= code_d;
    end
  end

  assign addr = addr_q;
  assign code = code_q;
endmodule

// File: rtl/vhp_fetch.sv
module vhp_fetch #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_fetch,
  input  logic [ADDR_W-1:0] setup_addr,
  input  logic              dat_rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] vram_rdata,
  output logic              vram_re,
  output logic [ADDR_W-1:0] vram_raddr,
  output logic              busy,
  output logic [DATA_W-1:0] rbuf
);
  logic              busy_q, busy_d;
  logic [DATA_W-1:0] buf_q, buf_d;

  assign vram_re    = setup_fetch | dat_rd;
  assign vram_raddr = setup_fetch ? setup_addr : addr;

  always_comb begin
    busy_d = vram_re;
    buf_d  = busy_q ? vram_rdata : buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (busy_q) buf_q <= buf_d;
    end
  end

  assign busy = busy_q;
  assign rbuf = buf_q;
endmodule

// File: rtl/vhp_wr_route.sv
module vhp_wr_route
  import vhp_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 8,
  parameter int CRAM_AW = 5
) (
  input  logic               dat_wr,
  input  acc_code_e          code,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic               vram_we,
  output logic [ADDR_W-1:0]  vram_waddr,
  output logic [DATA_W-1:0]  vram_wdata,
  output logic               cram_we,
  output logic [CRAM_AW-1:0] cram_addr,
  output logic [DATA_W-1:0]  cram_wdata
);
  logic to_cram;

  always_comb begin
    to_cram    = (code == ACC_CWR);
    vram_we    = dat_wr & ~to_cram;
    cram_we    = dat_wr & to_cram;
    vram_waddr = addr;
    vram_wdata = wdata;
    cram_addr  = addr[CRAM_AW-1:0];
    cram_wdata = wdata;
  end
endmodule

// File: rtl/vhp_resp.sv
module vhp_resp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_rd,
  input  logic              stat_rd,
  input  logic [DATA_W-1:0] rbuf,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              clr_pulse
);
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, clr_q, rd_en;

  assign rd_en = dat_rd | stat_rd;

  always_comb begin
    rdata_d = stat_rd ? status_in : rbuf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      clr_q    <= stat_rd;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rdata     = rdata_q;
  assign rvalid    = rvalid_q;
  assign clr_pulse = clr_q;
endmodule

// File: rtl/vid_host_port.sv
module vid_host_port
  import vhp_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 8,
  parameter int CRAM_AW = 5,
  parameter int REG_IW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr,
  input  logic               cpu_rd,
  input  logic               cpu_sel,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               cpu_rvalid,
  output logic               cpu_ready,
  output logic               vram_we,
  output logic [ADDR_W-1:0]  vram_waddr,
  output logic [DATA_W-1:0]  vram_wdata,
  output logic               vram_re,
  output logic [ADDR_W-1:0]  vram_raddr,
  input  logic [DATA_W-1:0]  vram_rdata,
  output logic               cram_we,
  output logic [CRAM_AW-1:0] cram_addr,
  output logic [DATA_W-1:0]  cram_wdata,
  output logic               reg_we,
  output logic [REG_IW-1:0]  reg_idx,
  output logic [DATA_W-1:0]  reg_wdata,
  input  logic [DATA_W-1:0]  status_in,
  output logic               stat_clr,
  output logic               irq_clr
);
  logic              rst_n_s;
  logic              busy, wr_ok, rd_ok;
  logic              ctl_wr, dat_wr, dat_rd, stat_rd;
  logic [ADDR_W-1:0] addr, setup_addr;
  acc_code_e         code;
  logic              setup_fetch, clr_pulse;
  logic [DATA_W-1:0] rbuf;

  vhp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  assign cpu_ready = ~busy;
  assign wr_ok     = cpu_wr & cpu_ready;
  assign rd_ok     = cpu_rd & ~cpu_wr & cpu_ready;
  assign ctl_wr    = wr_ok & cpu_sel;
  assign dat_wr    = wr_ok & ~cpu_sel;
  assign dat_rd    = rd_ok & ~cpu_sel;
  assign stat_rd   = rd_ok & cpu_sel;

  vhp_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_IW(REG_IW)) u_cmd (
    .clk(clk), .rst_n(rst_n_s),
    .ctl_wr(ctl_wr), .dat_acc(dat_wr | dat_rd), .stat_rd(stat_rd),
    .wdata(cpu_wdata), .addr(addr), .code(code),
    .setup_fetch(setup_fetch), .setup_addr(setup_addr),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata)
  );

  vhp_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk(clk), .rst_n(rst_n_s),
    .setup_fetch(setup_fetch), .setup_addr(setup_addr),
    .dat_rd(dat_rd), .addr(addr), .vram_rdata(vram_rdata),
    .vram_re(vram_re), .vram_raddr(vram_raddr),
    .busy(busy), .rbuf(rbuf)
  );

  vhp_wr_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CRAM_AW(CRAM_AW)) u_wr (
    .dat_wr(dat_wr), .code(code), .addr(addr), .wdata(cpu_wdata),
    .vram_we(vram_we), .vram_waddr(vram_waddr), .vram_wdata(vram_wdata),
    .cram_we(cram_we), .cram_addr(cram_addr), .cram_wdata(cram_wdata)
  );

  vhp_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n_s),
    .dat_rd(dat_rd), .stat_rd(stat_rd), .rbuf(rbuf), .status_in(status_in),
    .rdata(cpu_rdata), .rvalid(cpu_rvalid), .clr_pulse(clr_pulse)
  );

  assign stat_clr = clr_pulse;
  assign irq_clr  = clr_pulse;
endmodule

// File: rtl/vid_host_port_chk.sv
module vid_host_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic              cpu_sel,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_rvalid,
  input logic              cpu_ready,
  input logic              vram_we,
  input logic              vram_re,
  input logic              cram_we,
  input logic              reg_we,
  input logic              stat_clr,
  input logic              irq_clr
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> !(vram_we || cram_we || reg_we));

  assert_fetch_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vram_re |=> !cpu_ready);

  assert_status_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && cpu_sel && cpu_ready) |=> (stat_clr && irq_clr && cpu_rvalid));

  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(vram_we && cram_we));

  assert_reg_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (cpu_wr && cpu_sel && cpu_wdata[DATA_W-1 -: 2] == 2'b10));

  assert_rvalid_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && cpu_rvalid) |-> $past(cpu_rd && !cpu_wr));
endmodule

bind vid_host_port vid_host_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid),
  .cpu_ready(cpu_ready), .vram_we(vram_we), .vram_re(vram_re),
  .cram_we(cram_we), .reg_we(reg_we), .stat_clr(stat_clr), .irq_clr(irq_clr)
);

// File: tb/test_vid_host_port.sv
module test_vid_host_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_sel = 1'b0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic cpu_rvalid, cpu_ready;
  logic vram_we, vram_re;
  logic [13:0] vram_waddr, vram_raddr;
  logic [7:0] vram_wdata;
  logic [7:0] vram_rdata = 8'h00;
  logic cram_we;
  logic [4:0] cram_addr;
  logic [7:0] cram_wdata;
  logic reg_we;
  logic [3:0] reg_idx;
  logic [7:0] reg_wdata;
  logic [7:0] status_in = 8'h00;
  logic stat_clr, irq_clr;

  int n_checks = 0;
  int n_fail = 0;

  // snapshot of same-cycle outputs
  logic s_vwe, s_vre, s_cwe, s_rwe;
  logic [13:0] s_vwa, s_vra;
  logic [7:0] s_vwd, s_cwd, s_rwd;
  logic [4:0] s_ca;
  logic [3:0] s_ri;

  logic [7:0] mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_host_port i_vid_host_port (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .cpu_ready(cpu_ready), .vram_we(vram_we), .vram_waddr(vram_waddr),
    .vram_wdata(vram_wdata), .vram_re(vram_re), .vram_raddr(vram_raddr),
    .vram_rdata(vram_rdata), .cram_we(cram_we), .cram_addr(cram_addr),
    .cram_wdata(cram_wdata), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .status_in(status_in), .stat_clr(stat_clr),
    .irq_clr(irq_clr)
  );

  // synchronous video memory model, one cycle read latency
  always @(posedge clk) begin
    if (vram_we) mem[int'(vram_waddr)] = vram_wdata;
    if (vram_re) vram_rdata <= mem.exists(int'(vram_raddr)) ? mem[int'(vram_raddr)] : 8'h00;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic s, input logic [7:0] d);
    while (!cpu_ready) @(negedge clk);
    cpu_wr = w; cpu_rd = !w; cpu_sel = s; cpu_wdata = d;
    #1;
    s_vwe = vram_we; s_vwa = vram_waddr; s_vwd = vram_wdata;
    s_vre = vram_re; s_vra = vram_raddr;
    s_cwe = cram_we; s_ca = cram_addr; s_cwd = cram_wdata;
    s_rwe = reg_we; s_ri = reg_idx; s_rwd = reg_wdata;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ready", cpu_ready, 1);
    chk("R1 rvalid", cpu_rvalid, 0);
    chk("R1 strobes", {vram_we, cram_we, reg_we, stat_clr, irq_clr}, 0);

    // R2/R4 register load sweep over every index
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = 8'((i * 37) ^ 8'h5A);
      access(1'b1, 1'b1, v);
      chk("R2 no strobe on first byte", {s_vwe, s_cwe, s_rwe}, 0);
      access(1'b1, 1'b1, 8'hB0 | 8'(i));
      chk("R4 reg_we", s_rwe, 1);
      chk("R4 reg_idx", s_ri, i);
      chk("R4 reg_wdata", s_rwd, v);
    end

    // R3/R5 video write with wrap across 0x3FFF
    access(1'b1, 1'b1, 8'hF0);
    access(1'b1, 1'b1, 8'h7F);
    chk("R3 no stall for write kind", cpu_ready, 1);
    for (int k = 0; k < 32; k++) begin
      int a;
      a = (16'h3FF0 + k) & 16'h3FFF;
      access(1'b1, 1'b0, pat(a));
      chk("R5 vram_we", s_vwe, 1);
      chk("R5 vram_waddr", s_vwa, a);
      chk("R5 vram_wdata", s_vwd, pat(a));
    end

    // R3/R7 read setup then buffered sequential read
    access(1'b1, 1'b1, 8'hF0);
    access(1'b1, 1'b1, 8'h3F);
    chk("R3 setup fetch re", s_vre, 1);
    chk("R3 setup fetch addr", s_vra, 16'h3FF0);
    chk("R3 stall after fetch", cpu_ready, 0);
    for (int k = 0; k < 32; k++) begin
      access(1'b0, 1'b0, 8'h00);
      chk("R7 rvalid", cpu_rvalid, 1);
      chk("R7 rdata", cpu_rdata, pat((16'h3FF0 + k) & 16'h3FFF));
      chk("R7 refill addr", s_vra, (16'h3FF1 + k) & 16'h3FFF);
    end

    // R6 colour writes beyond the 32-entry range
    access(1'b1, 1'b1, 8'h00);
    access(1'b1, 1'b1, 8'hC0);
    for (int k = 0; k < 40; k++) begin
      access(1'b1, 1'b0, pat(k) ^ 8'hFF);
      chk("R6 cram_we", s_cwe, 1);
      chk("R6 no vram_we", s_vwe, 0);
      chk("R6 cram_addr", s_ca, k & 31);
      chk("R6 cram_wdata", s_cwd, pat(k) ^ 8'hFF);
    end

    // R2/R8 first byte then data write abandons the sequence
    access(1'b1, 1'b1, 8'h12);
    access(1'b1, 1'b0, 8'h99);
    chk("R2 low pointer from first byte", s_ca, 8'h12 & 31);
    access(1'b1, 1'b1, 8'h34);
    access(1'b1, 1'b1, 8'h40);
    access(1'b1, 1'b0, 8'h66);
    chk("R8 after data write", s_vwa, 16'h0034);

    // R8 data read also abandons the sequence
    access(1'b1, 1'b1, 8'h55);
    access(1'b0, 1'b0, 8'h00);
    access(1'b1, 1'b1, 8'h20);
    access(1'b1, 1'b1, 8'h42);
    access(1'b1, 1'b0, 8'h11);
    chk("R8 after data read", s_vwa, 16'h0220);

    // R9 status read
    status_in = 8'hA5;
    access(1'b1, 1'b1, 8'h77);
    access(1'b0, 1'b1, 8'h00);
    chk("R9 rdata", cpu_rdata, 8'hA5);
    chk("R9 rvalid", cpu_rvalid, 1);
    chk("R9 clear pulses", {stat_clr, irq_clr}, 2'b11);
    @(negedge clk);
    chk("R9 pulse width", {stat_clr, irq_clr}, 2'b00);
    access(1'b1, 1'b1, 8'h00);
    access(1'b1, 1'b1, 8'h41);
    access(1'b1, 1'b0, 8'h5C);
    chk("R9 sequence abandoned", s_vwa, 16'h0100);

    // R10 write during refill is ignored
    access(1'b1, 1'b1, 8'h00);
    access(1'b1, 1'b1, 8'h01);
    chk("R10 stalled", cpu_ready, 0);
    cpu_wr = 1'b1; cpu_sel = 1'b0; cpu_wdata = 8'hEE;
    #1;
    chk("R10 no write while stalled", {vram_we, cram_we, reg_we}, 0);
    @(negedge clk);
    cpu_wr = 1'b0;
    access(1'b0, 1'b0, 8'h00);
    chk("R10 buffered byte", cpu_rdata, 8'h5C);
    access(1'b0, 1'b0, 8'h00);
    chk("R10 pointer unchanged", cpu_rdata, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule